// File: doc/BRIEF.md
# Thread Block Admission Dispatcher

This block takes thread-block launch requests, one at a time, from the head of a request queue and places each block on one of several compute cores. Every request gives a thread count, a shared-memory size in bytes and an identifier. For each core the dispatcher keeps a count of free warp execution contexts and a shared-memory bump pointer. A block is placed only when one core can take all of its warps and all of its shared memory in the same cycle. If no core can, the queue stalls.

Each placement appears on a registered assignment handshake that carries the core index, the block identifier and the byte base of the block's shared-memory region. Cores report finished blocks on a completion input that returns the block's warp contexts. The shared memory of a core is reclaimed as a whole when that core becomes completely idle. A request that could never fit any core is consumed, dropped and reported on a one-cycle error pulse.

Top module: `tblk_admit`

## Requirements
- R1: A block needs ceil(threads/32) warps. It can only go to a core whose free warp count is at least that number, and the warps are deducted on the accepting clock edge. No core ever holds more than 64 warps.
- R2: A block needs ceil(bytes/256) shared-memory granules of the 512 granules a core has. A core fits only if its bump pointer plus the need is at most 512. A core that is short of memory is skipped even if it has enough free warps.
- R3: When several cores fit, the block goes to the one with the lowest index. The index appears on `asg_core`.
- R4: Requests are served strictly in order. While the head request fits no core, or while a pending assignment is not taken, `req_ready` stays low and nothing behind the head moves. `asg_id` carries the identifier of the accepted head.
- R5: A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. `asg_valid` rises on that edge. It then holds, with stable fields, until a cycle with `asg_ready` high. A new block may be accepted in that same cycle.
- R6: `asg_smem_base` equals the core's bump pointer in bytes before the allocation, so it is a multiple of 256. The pointer then advances by the block's granules.
- R7: A completion (`cmp_valid`, `cmp_core`, `cmp_warps`) sampled at clock edge E is registered first. Its warps are added back at edge E+1, so the first admission decision that can use them is the one made at edge E+2.
- R8: When a core's free warp count returns to 64, its bump pointer goes back to zero, and the next block placed there gets base 0.
- R9: A request with zero threads, more than 64 warps, or more than 131072 bytes is accepted at once (`req_ready` high) and dropped. It consumes no resources. `err_valid` pulses on the next cycle with that request's identifier on `err_id`.
- R10: While reset is applied, `asg_valid`, `err_valid` and `req_ready` are low. After reset every core is fully free, so a request for 64 warps and 131072 bytes is ready at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Head request present |
| req_ready | output | 1 | Head request accepted this cycle (placed or dropped) |
| req_threads | input | THREAD_W | Thread count of the block |
| req_smem | input | SMEM_W | Shared-memory bytes of the block |
| req_id | input | ID_W | Block identifier |
| asg_valid | output | 1 | Assignment pending |
| asg_ready | input | 1 | Receiver takes the assignment |
| asg_core | output | CORE_W | Chosen core index |
| asg_id | output | ID_W | Identifier of the placed block |
| asg_smem_base | output | SMEM_W | Byte base of the block's shared-memory region |
| err_valid | output | 1 | One-cycle pulse for a dropped request |
| err_id | output | ID_W | Identifier of the dropped request |
| cmp_valid | input | 1 | Completion pulse from a core |
| cmp_core | input | CORE_W | Core that finished a block |
| cmp_warps | input | WARP_W | Warp count returned |

## Verification
The bench aims at a core that has free warps but too little memory left. A design that tests only warps would place the block there instead of at a higher index. It also stalls the queue behind a whole-core block. A design that reorders or places part of a block would move a later identifier early. The bench checks the exact cycle in which returned warps become usable and in which the bump pointer restarts at zero. A design that adds completions one cycle early, or never resets the pointer, would show a wrong core, a wrong stall length or a non-zero base. Oversized and zero-thread requests, and back-pressure on the assignment handshake, show up as lost identifiers, resource leaks or fields that change while an assignment is held.

// File: rtl/tblk_admit_pkg.sv
package tblk_admit_pkg;

  // Default geometry shared by the block and its checker.
  localparam int DEF_NUM_CORES      = 4;
  localparam int DEF_WARP_SIZE      = 32;
  localparam int DEF_WARPS_PER_CORE = 64;
  localparam int DEF_SMEM_BYTES     = 131072;
  localparam int DEF_GRANULE        = 256;

  // Width able to hold the value v (v >= 1).
  function automatic int cnt_width(input int v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/tblk_rst_sync.sv
module tblk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_ns = sync_q[1];

endmodule

// File: rtl/tblk_req_decode.sv
module tblk_req_decode #(
  parameter int THREAD_W       = 12,
  parameter int SMEM_W         = 18,
  parameter int WARP_SIZE      = 32,
  parameter int WARPS_PER_CORE = 64,
  parameter int SMEM_BYTES     = 131072,
  parameter int GRANULE        = 256,
  parameter int NW_W           = 8,
  parameter int NG_W           = 11
) (
  input  logic [THREAD_W-1:0] threads,
  input  logic [SMEM_W-1:0]   smem,
  output logic [NW_W-1:0]     need_w,
  output logic [NG_W-1:0]     need_g,
  output logic                bad
);

  localparam int WS_LG = $clog2(WARP_SIZE);
  localparam int GR_LG = $clog2(GRANULE);
  localparam logic [THREAD_W:0] T_RND   = (THREAD_W+1)'(WARP_SIZE - 1);
  localparam logic [SMEM_W:0]   S_RND   = (SMEM_W+1)'(GRANULE - 1);
  localparam logic [NW_W-1:0]   W_LIMIT = NW_W'(WARPS_PER_CORE);
  localparam logic [SMEM_W:0]   S_LIMIT = (SMEM_W+1)'(SMEM_BYTES);

  logic [THREAD_W:0] t_sum;
  logic [SMEM_W:0]   s_sum;

  always_comb begin
    t_sum  = {1'b0, threads} + T_RND;
    s_sum  = {1'b0, smem} + S_RND;
    need_w = NW_W'(t_sum >> WS_LG);
    need_g = NG_W'(s_sum >> GR_LG);
    bad    = (need_w == '0) || (need_w > W_LIMIT) || ({1'b0, smem} > S_LIMIT);
  end

endmodule

// File: rtl/tblk_core_ledger.sv
module tblk_core_ledger #(
  parameter int WARPS_PER_CORE = 64,
  parameter int TOTAL_GRAN     = 512,
  parameter int WARP_W         = 7,
  parameter int GRAN_W         = 10,
  parameter int NW_W           = 8,
  parameter int NG_W           = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NW_W-1:0]   need_w,
  input  logic [NG_W-1:0]   need_g,
  input  logic              take,
  input  logic              ret_valid,
  input  logic [WARP_W-1:0] ret_warps,
  output logic              fits,
  output logic [WARP_W-1:0] free_w,
  output logic [GRAN_W-1:0] bump
);

  localparam int SUM_W = ((NG_W > GRAN_W) ? NG_W : GRAN_W) + 1;
  localparam logic [WARP_W-1:0] W_FULL = WARP_W'(WARPS_PER_CORE);
  localparam logic [SUM_W-1:0]  G_CAP  = SUM_W'(TOTAL_GRAN);

  logic [WARP_W-1:0] free_q, free_n;
  logic [GRAN_W-1:0] bump_q, bump_n;
  logic [SUM_W-1:0]  g_end;
  logic              upd;

  // Fit test on registered state only.
  always_comb begin
    g_end = SUM_W'(bump_q) + SUM_W'(need_g);
    fits  = (NW_W'(free_q) >= need_w) && (g_end <= G_CAP);
  end

  // Next state: deduct on take, add back on return, reclaim memory when idle.
  always_comb begin
    free_n = free_q;
    bump_n = bump_q;
    if (take) begin
      free_n = free_n - need_w[WARP_W-1:0];
      bump_n = bump_n + need_g[GRAN_W-1:0];
    end
    if (ret_valid) begin
      free_n = free_n + ret_warps;
    end
    if (free_n == W_FULL) begin
      bump_n = '0;
    end
    upd = take | ret_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q <= W_FULL;
      bump_q <= '0;
    end else if (upd) begin
      free_q <= free_n;
      bump_q <= bump_n;
    end
  end

  assign free_w = free_q;
  assign bump   = bump_q;

endmodule

// File: rtl/tblk_core_pick.sv
module tblk_core_pick #(
  parameter int NUM_CORES = 4,
  parameter int CORE_W    = 2
) (
  input  logic [NUM_CORES-1:0] fits,
  output logic                 any,
  output logic [CORE_W-1:0]    idx
);

  // Lowest index wins: scan downward so the last hit is the smallest.
  always_comb begin
    any = |fits;
    idx = '0;
    for (int i = NUM_CORES - 1; i >= 0; i--) begin
      if (fits[i]) begin
        idx = CORE_W'(i);
      end
    end
  end

endmodule

// File: rtl/tblk_admit.sv
module tblk_admit
  import tblk_admit_pkg::*;
#(
  parameter int NUM_CORES      = DEF_NUM_CORES,
  parameter int WARP_SIZE      = DEF_WARP_SIZE,
  parameter int WARPS_PER_CORE = DEF_WARPS_PER_CORE,
  parameter int SMEM_BYTES     = DEF_SMEM_BYTES,
  parameter int GRANULE        = DEF_GRANULE,
  parameter int THREAD_W       = 12,
  parameter int SMEM_W         = 18,
  parameter int ID_W           = 8,
  localparam int CORE_W        = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int WARP_W        = cnt_width(WARPS_PER_CORE)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [THREAD_W-1:0] req_threads,
  input  logic [SMEM_W-1:0]   req_smem,
  input  logic [ID_W-1:0]     req_id,
  output logic                asg_valid,
  input  logic                asg_ready,
  output logic [CORE_W-1:0]   asg_core,
  output logic [ID_W-1:0]     asg_id,
  output logic [SMEM_W-1:0]   asg_smem_base,
  output logic                err_valid,
  output logic [ID_W-1:0]     err_id,
  input  logic                cmp_valid,
  input  logic [CORE_W-1:0]   cmp_core,
  input  logic [WARP_W-1:0]   cmp_warps
);

  localparam int GR_LG      = $clog2(GRANULE);
  localparam int TOTAL_GRAN = SMEM_BYTES / GRANULE;
  localparam int GRAN_W     = cnt_width(TOTAL_GRAN);
  localparam int NW_W       = THREAD_W + 1 - $clog2(WARP_SIZE);
  localparam int NG_W       = SMEM_W + 1 - GR_LG;

  logic rst_ns;

  tblk_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  // Head request decode.
  logic [NW_W-1:0] need_w;
  logic [NG_W-1:0] need_g;
  logic            bad;

  tblk_req_decode #(
    .THREAD_W       (THREAD_W),
    .SMEM_W         (SMEM_W),
    .WARP_SIZE      (WARP_SIZE),
    .WARPS_PER_CORE (WARPS_PER_CORE),
    .SMEM_BYTES     (SMEM_BYTES),
    .GRANULE        (GRANULE),
    .NW_W           (NW_W),
    .NG_W           (NG_W)
  ) u_dec (
    .threads (req_threads),
    .smem    (req_smem),
    .need_w  (need_w),
    .need_g  (need_g),
    .bad     (bad)
  );

  // Completion stage: one register between the cores and the ledgers.
  logic              cmp_v_q, cmp_v_n;
  logic [CORE_W-1:0] cmp_c_q, cmp_c_n;
  logic [WARP_W-1:0] cmp_w_q, cmp_w_n;

  // Assignment and error output registers.
  logic              asg_v_q, asg_v_n;
  logic [CORE_W-1:0] asg_c_q, asg_c_n;
  logic [ID_W-1:0]   asg_i_q, asg_i_n;
  logic [SMEM_W-1:0] asg_b_q, asg_b_n;
  logic              err_v_q, err_v_n;
  logic [ID_W-1:0]   err_i_q, err_i_n;
  logic              asg_en, err_en;

  // Per-core ledgers.
  logic [NUM_CORES-1:0]        fits, take, ret;
  logic [WARP_W-1:0]           free_arr [NUM_CORES];
  logic [GRAN_W-1:0]           bump_arr [NUM_CORES];
  logic [NUM_CORES*WARP_W-1:0] free_all;
  logic [NUM_CORES*GRAN_W-1:0] bump_all;
  logic                        any_fit;
  logic [CORE_W-1:0]           pick_idx;
  logic                        slot_free, acc, place, drop;

  assign slot_free = !asg_v_q || asg_ready;
  assign req_ready = rst_ns && (bad || (any_fit && slot_free));
  assign acc       = req_valid && req_ready;
  assign place     = acc && !bad;
  assign drop      = acc && bad;

  generate
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      assign take[c] = place && (pick_idx == CORE_W'(c));
      assign ret[c]  = cmp_v_q && (cmp_c_q == CORE_W'(c));

      tblk_core_ledger #(
        .WARPS_PER_CORE (WARPS_PER_CORE),
        .TOTAL_GRAN     (TOTAL_GRAN),
        .WARP_W         (WARP_W),
        .GRAN_W         (GRAN_W),
        .NW_W           (NW_W),
        .NG_W           (NG_W)
      ) u_led (
        .clk       (clk),
        .rst_n     (rst_ns),
        .need_w    (need_w),
        .need_g    (need_g),
        .take      (take[c]),
        .ret_valid (ret[c]),
        .ret_warps (cmp_w_q),
        .fits      (fits[c]),
        .free_w    (free_arr[c]),
        .bump      (bump_arr[c])
      );

      assign free_all[c*WARP_W +: WARP_W] = free_arr[c];
      assign bump_all[c*GRAN_W +: GRAN_W] = bump_arr[c];
    end
  endgenerate

  tblk_core_pick #(
    .NUM_CORES (NUM_CORES),
    .CORE_W    (CORE_W)
  ) u_pick (
    .fits (fits),
    .any  (any_fit),
    .idx  (pick_idx)
  );

  // Next-state for the output and completion registers.
  always_comb begin
    asg_v_n = asg_v_q;
    asg_c_n = asg_c_q;
    asg_i_n = asg_i_q;
    asg_b_n = asg_b_q;
    if (place) begin
      asg_v_n = 1'b1;
      asg_c_n = pick_idx;
      asg_i_n = req_id;
      asg_b_n = SMEM_W'({bump_arr[pick_idx], {GR_LG{1'b0}}});
    end else if (asg_ready) begin
      asg_v_n = 1'b0;
    end
    asg_en  = place || (asg_v_q && asg_ready);

    err_v_n = drop;
    err_i_n = drop ? req_id : err_i_q;
    err_en  = drop || err_v_q;

    cmp_v_n = cmp_valid;
    cmp_c_n = cmp_valid ? cmp_core  : cmp_c_q;
    cmp_w_n = cmp_valid ? cmp_warps : cmp_w_q;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      asg_v_q <= 1'b0;
      asg_c_q <= '0;
      asg_i_q <= '0;
      asg_b_q <= '0;
    end else if (asg_en) begin
      asg_v_q <= asg_v_n;
      asg_c_q <= asg_c_n;
      asg_i_q <= asg_i_n;
      asg_b_q <= asg_b_n;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      err_v_q <= 1'b0;
      err_i_q <= '0;
    end else if (err_en) begin
      err_v_q <= err_v_n;
      err_i_q <= err_i_n;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      cmp_v_q <= 1'b0;
      cmp_c_q <= '0;
      cmp_w_q <= '0;
    end else begin
      cmp_v_q <= cmp_v_n;
      cmp_c_q <= cmp_c_n;
      cmp_w_q <= cmp_w_n;
    end
  end

  assign asg_valid     = asg_v_q;
  assign asg_core      = asg_c_q;
  assign asg_id        = asg_i_q;
  assign asg_smem_base = asg_b_q;
  assign err_valid     = err_v_q;
  assign err_id        = err_i_q;

endmodule

// File: rtl/tblk_admit_chk.sv
module tblk_admit_chk #(
  parameter int NUM_CORES      = 4,
  parameter int WARPS_PER_CORE = 64,
  parameter int TOTAL_GRAN     = 512,
  parameter int GR_LG          = 8,
  parameter int CORE_W         = 2,
  parameter int WARP_W         = 7,
  parameter int GRAN_W         = 10,
  parameter int ID_W           = 8,
  parameter int SMEM_W         = 18
) (
  input logic                        clk,
  input logic                        rst_ni,
  input logic                        req_valid,
  input logic                        req_ready,
  input logic                        asg_valid,
  input logic                        asg_ready,
  input logic [CORE_W-1:0]           asg_core,
  input logic [ID_W-1:0]             asg_id,
  input logic [SMEM_W-1:0]           asg_smem_base,
  input logic                        err_valid,
  input logic [NUM_CORES*WARP_W-1:0] free_all,
  input logic [NUM_CORES*GRAN_W-1:0] bump_all
);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (asg_valid && !asg_ready) |=> (asg_valid && $stable(asg_core) && $stable(asg_id) && $stable(asg_smem_base)));

  assert_new_from_accept_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(asg_valid) |-> $past(req_valid && req_ready));

  assert_err_from_accept_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    err_valid |-> $past(req_valid && req_ready));

  assert_base_align_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    asg_valid |-> (asg_smem_base[GR_LG-1:0] == '0));

  assert_core_range_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    asg_valid |-> (int'(asg_core) < NUM_CORES));

  generate
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_cap
      assert_warp_cap_R1: assert property (@(posedge clk) disable iff (!rst_ni)
        int'(free_all[c*WARP_W +: WARP_W]) <= WARPS_PER_CORE);

      assert_smem_cap_R2: assert property (@(posedge clk) disable iff (!rst_ni)
        int'(bump_all[c*GRAN_W +: GRAN_W]) <= TOTAL_GRAN);

      assert_idle_reset_R8: assert property (@(posedge clk) disable iff (!rst_ni)
        (int'(free_all[c*WARP_W +: WARP_W]) == WARPS_PER_CORE) |-> (bump_all[c*GRAN_W +: GRAN_W] == '0));
    end
  endgenerate

endmodule

bind tblk_admit tblk_admit_chk #(
  .NUM_CORES      (NUM_CORES),
  .WARPS_PER_CORE (WARPS_PER_CORE),
  .TOTAL_GRAN     (TOTAL_GRAN),
  .GR_LG          (GR_LG),
  .CORE_W         (CORE_W),
  .WARP_W         (WARP_W),
  .GRAN_W         (GRAN_W),
  .ID_W           (ID_W),
  .SMEM_W         (SMEM_W)
) u_chk (
  .clk           (clk),
  .rst_ni        (rst_ns),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .asg_valid     (asg_valid),
  .asg_ready     (asg_ready),
  .asg_core      (asg_core),
  .asg_id        (asg_id),
  .asg_smem_base (asg_smem_base),
  .err_valid     (err_valid),
  .free_all      (free_all),
  .bump_all      (bump_all)
);

// File: tb/sim_tblk_admit.sv
module sim_tblk_admit;

  localparam int NC  = 4;
  localparam int MAXW = 64;
  localparam int MAXG = 512;
  localparam int MAXB = 131072;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_threads = 12'd2048;
  logic [17:0] req_smem = 18'd131072;
  logic [7:0]  req_id = 8'd0;
  logic        asg_valid;
  logic        asg_ready = 1'b1;
  logic [1:0]  asg_core;
  logic [7:0]  asg_id;
  logic [17:0] asg_smem_base;
  logic        err_valid;
  logic [7:0]  err_id;
  logic        cmp_valid = 1'b0;
  logic [1:0]  cmp_core = 2'd0;
  logic [6:0]  cmp_warps = 7'd0;

  always #10 clk = ~clk;

  tblk_admit u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_threads(req_threads),
    .req_smem(req_smem), .req_id(req_id),
    .asg_valid(asg_valid), .asg_ready(asg_ready), .asg_core(asg_core),
    .asg_id(asg_id), .asg_smem_base(asg_smem_base),
    .err_valid(err_valid), .err_id(err_id),
    .cmp_valid(cmp_valid), .cmp_core(cmp_core), .cmp_warps(cmp_warps)
  );

  // Request list.
  int rq_thr [200];
  int rq_sm  [200];
  int rq_life[200];
  int n_rq = 0;

  task automatic add_rq(input int t, input int s, input int life);
    rq_thr[n_rq] = t; rq_sm[n_rq] = s; rq_life[n_rq] = life; n_rq++;
  endtask

  // Reference model state.
  int  m_free[NC];
  int  m_bump[NC];
  bit  m_asg_v = 0;
  int  m_asg_c = 0, m_asg_i = 0, m_asg_b = 0;
  bit  m_err_v = 0;
  int  m_err_i = 0;
  bit  m_pend_v = 0;
  int  m_pend_c = 0, m_pend_w = 0;
  bit  model_on = 0;
  bit  acc_last = 0;
  int  req_idx = 0;

  // Outstanding blocks whose completion the bench will later report.
  int ob_core[256];
  int ob_w   [256];
  int ob_life[256];
  bit ob_act [256];
  int n_ob = 0;

  int n_cmp = 0, n_fail = 0, cyc = 0, done_cyc = 0;

  function automatic int wneed(input int t);
    return (t + 31) / 32;
  endfunction

  function automatic int gneed(input int s);
    return (s + 255) / 256;
  endfunction

  function bit m_bad();
    int w;
    w = wneed(int'(req_threads));
    return (w == 0) || (w > MAXW) || (int'(req_smem) > MAXB);
  endfunction

  function int m_pick();
    int w, g;
    w = wneed(int'(req_threads));
    g = gneed(int'(req_smem));
    for (int c = 0; c < NC; c++) begin
      if (m_free[c] >= w && m_bump[c] + g <= MAXG) return c;
    end
    return -1;
  endfunction

  function bit m_ready();
    if (m_bad()) return 1'b1;
    return (m_pick() >= 0) && (!m_asg_v || asg_ready);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  initial begin
    for (int c = 0; c < NC; c++) begin m_free[c] = MAXW; m_bump[c] = 0; end
    for (int k = 0; k < 256; k++) ob_act[k] = 1'b0;
    // R9: malformed requests are dropped.
    add_rq(0, 0, 5);
    add_rq(2080, 0, 5);
    add_rq(32, 131073, 5);
    // R1: whole core of warps goes to core 0.
    add_rq(2048, 0, 40);
    // R3: core 0 full, core 1 chosen, base 0.
    add_rq(64, 1000, 30);
    // R6: core 1 gets base 1024 and fills its memory.
    add_rq(32, 130048, 30);
    // R2: core 1 short of memory though warps are free, core 2 chosen.
    add_rq(32, 256, 30);
    // R4: whole-core block to core 3, then a second one must stall.
    add_rq(2048, 131072, 25);
    add_rq(2048, 0, 10);
    // R7 and R8: placed after completions, base restarts at 0.
    add_rq(100, 5000, 8);
    for (int k = 0; k < 80; k++) begin
      if (k % 17 == 5) add_rq(40, 140000, 3);
      else add_rq((k * 97) % 700 + 1, (k * 3001) % 40000, k % 13 + 3);
    end
  end

  // Reference model: advances at every rising edge from the inputs present.
  always @(posedge clk) begin
    bit acc, bad;
    int c, w, g;
    if (model_on) begin
      acc = req_valid && m_ready();
      bad = m_bad();
      c   = m_pick();
      w   = wneed(int'(req_threads));
      g   = gneed(int'(req_smem));
      if (acc && !bad) begin
        m_asg_v = 1'b1;
        m_asg_c = c;
        m_asg_i = int'(req_id);
        m_asg_b = m_bump[c] * 256;
        m_free[c] = m_free[c] - w;
        m_bump[c] = m_bump[c] + g;
        ob_core[n_ob] = c; ob_w[n_ob] = w; ob_life[n_ob] = rq_life[req_idx];
        ob_act[n_ob] = 1'b1; n_ob++;
      end else if (asg_ready) begin
        m_asg_v = 1'b0;
      end
      m_err_v = acc && bad;
      if (acc && bad) m_err_i = int'(req_id);
      if (m_pend_v) m_free[m_pend_c] = m_free[m_pend_c] + m_pend_w;
      m_pend_v = cmp_valid;
      m_pend_c = int'(cmp_core);
      m_pend_w = int'(cmp_warps);
      for (int k = 0; k < NC; k++) if (m_free[k] == MAXW) m_bump[k] = 0;
      acc_last = acc;
    end
  end

  // Compare, then drive the next inputs, away from the rising edge.
  always @(negedge clk) begin
    bit busy;
    cyc++;
    if (cyc == 3) begin
      chk("R10 asg_valid in reset", int'(asg_valid), 0);
      chk("R10 err_valid in reset", int'(err_valid), 0);
      chk("R10 req_ready in reset", int'(req_ready), 0);
    end
    if (cyc == 4) rst_n = 1'b1;
    if (cyc == 9) begin
      chk("R10 full request ready after reset", int'(req_ready), 1);
      chk("R10 asg_valid after reset", int'(asg_valid), 0);
      model_on = 1'b1;
    end else if (model_on) begin
      chk("R1/R2/R4 req_ready", int'(req_ready), int'(req_valid ? m_ready() : m_ready()));
      chk("R5 asg_valid", int'(asg_valid), int'(m_asg_v));
      if (m_asg_v) begin
        chk("R3/R7 asg_core", int'(asg_core), m_asg_c);
        chk("R4 asg_id", int'(asg_id), m_asg_i);
        chk("R6/R8 asg_smem_base", int'(asg_smem_base), m_asg_b);
      end
      chk("R9 err_valid", int'(err_valid), int'(m_err_v));
      if (m_err_v) chk("R9 err_id", int'(err_id), m_err_i);
    end

    if (model_on) begin
      if (acc_last) begin req_idx++; acc_last = 1'b0; end
      req_valid = (req_idx < n_rq);
      if (req_idx < n_rq) begin
        req_threads = 12'(rq_thr[req_idx]);
        req_smem    = 18'(rq_sm[req_idx]);
        req_id      = 8'(req_idx);
      end
      asg_ready = ((cyc % 5) != 2) && !(cyc >= 100 && cyc < 110);
      cmp_valid = 1'b0;
      busy = 1'b0;
      for (int k = 0; k < n_ob; k++) begin
        if (ob_act[k]) begin
          busy = 1'b1;
          ob_life[k]--;
          if (ob_life[k] <= 0 && !cmp_valid) begin
            cmp_valid = 1'b1;
            cmp_core  = 2'(ob_core[k]);
            cmp_warps = 7'(ob_w[k]);
            ob_act[k] = 1'b0;
          end
        end
      end
      if (req_idx >= n_rq && !busy && !m_asg_v) done_cyc++;
    end

    if (done_cyc > 20 || cyc > 30000) begin
      if (cyc > 30000) begin
        n_cmp++; n_fail++;
        $display("FAIL watchdog at cycle %0d: actual %0d expected %0d", cyc, req_idx, n_rq);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end

endmodule